// File: doc/BRIEF.md
# Two-Channel Bus-Cycle Breakpoint Comparator

This block sits beside a CPU bus and raises a user-break request when a bus cycle meets a programmed condition. Two channels, A and B, each check an 8-bit address-space identifier, a 32-bit address with a coarse low-bit mask, the kind of access (instruction fetch or data access), the direction, and optionally the operand size. A channel can also be restricted to cycles that the CPU originates. Channel B also compares the data bus under a per-bit mask. Channel A has no data comparison.

The two channels either act on their own or form a chain. In the chain, a channel A hit arms the unit and a later channel B hit raises the break. For instruction conditions, each channel says whether the break is taken before the matched instruction runs or after it retires. The exception logic reads this timing from a second output.

Software writes the condition registers through a simple write port. It clears the sticky per-channel hit flags through a write-only clear register.

Top module: `brk_unit`

## Requirements
- R1: After reset, brk_o, brk_post_o, armed_o, hit_a_o and hit_b_o are 0. Both channels are off, so no bus cycle raises a break.
- R2: A channel matches a cycle only when bus_valid_i is 1, bus_asid_i equals its identifier, and the access kind agrees with its kind field. Kind 1 needs bus_fetch_i=1, kind 2 needs bus_fetch_i=0, and kinds 0 and 3 turn the channel off.
- R3: Address mask code 0 compares all address bits. Code 1 ignores bits 9:0, code 2 ignores bits 11:0 and code 3 ignores the whole address.
- R4: The direction bit must equal bus_write_i. A size field of 0 ignores bus_size_i. Sizes 1, 2 and 3 (byte, word, longword) must equal it.
- R5: With the CPU-only bit set, a channel ignores cycles with bus_cpu_i=0.
- R6: Channel B also needs equality of bus_data_i and its data register on every bit whose data-mask bit is 0. Channel A matches whatever the data bus carries.
- R7: In independent mode (mode bit 0 = 0), a hit on either channel makes brk_o a one-cycle pulse in the cycle after the bus cycle.
- R8: In sequential mode (mode bit 0 = 1), a channel A hit sets armed_o and raises no break. A channel B hit while armed_o is 0 is ignored. A channel B hit while armed raises brk_o and clears armed_o.
- R9: Any write to the mode register clears armed_o.
- R10: brk_post_o pulses with brk_o only when every triggering channel is an instruction condition with its after-execution bit set. A before-execution trigger takes priority.
- R11: hit_a_o is set by every channel A hit. hit_b_o is set by every channel B hit that counts toward a break. Each flag holds until a clear-register write with bit 0 (A) or bit 1 (B) set. A hit in the same cycle as the clear wins.
- R12: The register offsets are 0 A id, 1 A address, 2 A control, 3 B id, 4 B address, 5 B control, 6 B data, 7 B data mask, 8 mode and 9 clear. Control bits are [1:0] mask code, [3:2] kind, [4] write, [6:5] size, [7] CPU-only and [8] after-execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register offset |
| cfg_wdata_i | input | 32 | Register write data |
| bus_valid_i | input | 1 | A bus cycle is present |
| bus_cpu_i | input | 1 | Cycle originated by the CPU |
| bus_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Operand size: 1 byte, 2 word, 3 longword |
| bus_asid_i | input | 8 | Current address-space identifier |
| bus_addr_i | input | 32 | Cycle address |
| bus_data_i | input | 32 | Cycle data |
| brk_o | output | 1 | Break request pulse |
| brk_post_o | output | 1 | Break is to be taken after execution |
| armed_o | output | 1 | Sequential mode has seen channel A |
| hit_a_o | output | 1 | Sticky channel A hit |
| hit_b_o | output | 1 | Sticky channel B hit |

## Verification
The only hidden state is the arm flag, and armed_o exposes it in the cycle after it changes. A stuck or lost arm is therefore seen directly, and it also shows one cycle later as a missing break or an unwanted break on the next channel B cycle. A wrong compare field shows as a missing or extra brk_o pulse in the cycle after the offending bus cycle. The sticky flags show whether the fault came from channel A or channel B. The bench walks a table of fetch cycles around the mask and identifier edges. It then drives directed sequences for chaining, re-arming, timing priority and clear-versus-set races.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    KIND_OFF  = 2'd0,
    KIND_INSN = 2'd1,
    KIND_DATA = 2'd2,
    KIND_OFF3 = 2'd3
  } kind_e;

  typedef struct packed {
    logic       post;
    logic       cpu_only;
    logic [1:0] size;
    logic       wr;
    kind_e      kind;
    logic [1:0] amask;
  } chan_ctl_t;

  localparam int CTL_W = $bits(chan_ctl_t);

  typedef enum logic [3:0] {
    REG_A_ID    = 4'd0,
    REG_A_ADDR  = 4'd1,
    REG_A_CTL   = 4'd2,
    REG_B_ID    = 4'd3,
    REG_B_ADDR  = 4'd4,
    REG_B_CTL   = 4'd5,
    REG_B_DATA  = 4'd6,
    REG_B_DMASK = 4'd7,
    REG_MODE    = 4'd8,
    REG_CLEAR   = 4'd9
  } reg_e;
endpackage

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [ASID_W-1:0] a_id_o,
  output logic [ADDR_W-1:0] a_addr_o,
  output chan_ctl_t         a_ctl_o,
  output logic [ASID_W-1:0] b_id_o,
  output logic [ADDR_W-1:0] b_addr_o,
  output chan_ctl_t         b_ctl_o,
  output logic [DATA_W-1:0] b_data_o,
  output logic [DATA_W-1:0] b_dmask_o,
  output logic              seq_o,
  output logic              mode_wr_o,
  output logic              clr_a_o,
  output logic              clr_b_o
);
  logic [3:0] sel;
  assign sel = addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_id_o    <= '0;
      a_addr_o  <= '0;
      a_ctl_o   <= '0;
      b_id_o    <= '0;
      b_addr_o  <= '0;
      b_ctl_o   <= '0;
      b_data_o  <= '0;
      b_dmask_o <= '0;
      seq_o     <= 1'b0;
    end else if (we_i) begin
      case (sel)
        REG_A_ID:    a_id_o    <= wdata_i[ASID_W-1:0];
        REG_A_ADDR:  a_addr_o  <= wdata_i[ADDR_W-1:0];
        REG_A_CTL:   a_ctl_o   <= chan_ctl_t'(wdata_i[CTL_W-1:0]);
        REG_B_ID:    b_id_o    <= wdata_i[ASID_W-1:0];
        REG_B_ADDR:  b_addr_o  <= wdata_i[ADDR_W-1:0];
        REG_B_CTL:   b_ctl_o   <= chan_ctl_t'(wdata_i[CTL_W-1:0]);
        REG_B_DATA:  b_data_o  <= wdata_i[DATA_W-1:0];
        REG_B_DMASK: b_dmask_o <= wdata_i[DATA_W-1:0];
        REG_MODE:    seq_o     <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign mode_wr_o = we_i && (sel == REG_MODE);
  assign clr_a_o   = we_i && (sel == REG_CLEAR) && wdata_i[0];
  assign clr_b_o   = we_i && (sel == REG_CLEAR) && wdata_i[1];
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int ASID_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter bit HAS_DATA  = 1'b0,
  parameter int MASK1_LSB = 10,
  parameter int MASK2_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] cmp_id_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  chan_ctl_t         ctl_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic [DATA_W-1:0] dmask_i,
  input  logic              bus_valid_i,
  input  logic              bus_cpu_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ASID_W-1:0] bus_asid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              match_o,
  output logic              pre_o
);
  logic [ADDR_W-1:0] amask;
  logic kind_ok, addr_ok, size_ok, dir_ok, cpu_ok, id_ok, data_ok;

  always_comb begin
    unique case (ctl_i.amask)
      2'd0:    amask = '1;
      2'd1:    amask = {ADDR_W{1'b1}} << MASK1_LSB;
      2'd2:    amask = {ADDR_W{1'b1}} << MASK2_LSB;
      default: amask = '0;
    endcase
  end

  always_comb begin
    unique case (ctl_i.kind)
      KIND_INSN: kind_ok = bus_fetch_i;
      KIND_DATA: kind_ok = !bus_fetch_i;
      default:   kind_ok = 1'b0;
    endcase
  end

  assign addr_ok = ((bus_addr_i ^ cmp_addr_i) & amask) == '0;
  assign size_ok = (ctl_i.size == 2'd0) || (ctl_i.size == bus_size_i);
  assign dir_ok  = ctl_i.wr == bus_write_i;
  assign cpu_ok  = !ctl_i.cpu_only || bus_cpu_i;
  assign id_ok   = bus_asid_i == cmp_id_i;

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = ((bus_data_i ^ cmp_data_i) & ~dmask_i) == '0;
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{cmp_data_i, dmask_i, bus_data_i};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign match_o = bus_valid_i && kind_ok && id_ok && addr_ok && size_ok
                 && dir_ok && cpu_ok && data_ok;
  assign pre_o   = !((ctl_i.kind == KIND_INSN) && ctl_i.post);

  // R2
  id_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (bus_valid_i && bus_asid_i == cmp_id_i));

  // R3
  full_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && ctl_i.amask == 2'd0) |-> (bus_addr_i == cmp_addr_i));

  // R4
  size_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && ctl_i.size != 2'd0) |-> (bus_size_i == ctl_i.size));
endmodule

// File: rtl/brk_seq.sv
module brk_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seq_i,
  input  logic mode_wr_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic ma_i,
  input  logic mb_i,
  input  logic pre_a_i,
  input  logic pre_b_i,
  output logic brk_o,
  output logic post_o,
  output logic armed_o,
  output logic hit_a_o,
  output logic hit_b_o
);
  logic fire_a, fire_b, fire, pre_any;
  logic armed_q, brk_q, post_q, hit_a_q, hit_b_q;

  assign fire_a  = !seq_i && ma_i;
  assign fire_b  = mb_i && (!seq_i || armed_q);
  assign fire    = fire_a || fire_b;
  assign pre_any = (fire_a && pre_a_i) || (fire_b && pre_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      brk_q   <= 1'b0;
      post_q  <= 1'b0;
      hit_a_q <= 1'b0;
      hit_b_q <= 1'b0;
    end else begin
      brk_q  <= fire;
      post_q <= fire && !pre_any;
      // disarm beats arm
      if (mode_wr_i || fire)   armed_q <= 1'b0;
      else if (seq_i && ma_i)  armed_q <= 1'b1;
      if (ma_i)                hit_a_q <= 1'b1;
      else if (clr_a_i)        hit_a_q <= 1'b0;
      if (fire_b)              hit_b_q <= 1'b1;
      else if (clr_b_i)        hit_b_q <= 1'b0;
    end
  end

  assign brk_o   = brk_q;
  assign post_o  = post_q;
  assign armed_o = armed_q;
  assign hit_a_o = hit_a_q;
  assign hit_b_o = hit_b_q;

  // R7
  brk_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |-> $past(ma_i || mb_i));

  // R8
  unarmed_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_i && mb_i && !armed_q) |=> !brk_q);

  // R8
  disarm_on_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q |-> !armed_q);

  // R9
  mode_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> !armed_q);

  // R11
  hit_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a_q && !clr_a_i) |=> hit_a_q);

  // R11
  hit_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_b_q && !clr_b_i) |=> hit_b_q);
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ASID_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MASK1_LSB = 10,
  parameter int MASK2_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              bus_valid_i,
  input  logic              bus_cpu_i,
  input  logic              bus_fetch_i,
  input  logic              bus_write_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ASID_W-1:0] bus_asid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              brk_o,
  output logic              brk_post_o,
  output logic              armed_o,
  output logic              hit_a_o,
  output logic              hit_b_o
);
  localparam int NCH = 2;

  logic [ASID_W-1:0] a_id, b_id;
  logic [ADDR_W-1:0] a_addr, b_addr;
  chan_ctl_t         a_ctl, b_ctl;
  logic [DATA_W-1:0] b_data, b_dmask;
  logic seq, mode_wr, clr_a, clr_b;

  logic [ASID_W-1:0] ch_id    [NCH];
  logic [ADDR_W-1:0] ch_addr  [NCH];
  chan_ctl_t         ch_ctl   [NCH];
  logic [DATA_W-1:0] ch_data  [NCH];
  logic [DATA_W-1:0] ch_dmask [NCH];
  logic [NCH-1:0]    ch_match, ch_pre;

  brk_cfg #(.ASID_W(ASID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .a_id_o(a_id), .a_addr_o(a_addr), .a_ctl_o(a_ctl),
    .b_id_o(b_id), .b_addr_o(b_addr), .b_ctl_o(b_ctl),
    .b_data_o(b_data), .b_dmask_o(b_dmask),
    .seq_o(seq), .mode_wr_o(mode_wr), .clr_a_o(clr_a), .clr_b_o(clr_b)
  );

  assign ch_id[0]    = a_id;
  assign ch_addr[0]  = a_addr;
  assign ch_ctl[0]   = a_ctl;
  assign ch_data[0]  = '0;
  assign ch_dmask[0] = '1;
  assign ch_id[1]    = b_id;
  assign ch_addr[1]  = b_addr;
  assign ch_ctl[1]   = b_ctl;
  assign ch_data[1]  = b_data;
  assign ch_dmask[1] = b_dmask;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    brk_chan #(
      .ASID_W(ASID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .HAS_DATA(c == 1), .MASK1_LSB(MASK1_LSB), .MASK2_LSB(MASK2_LSB)
    ) u_chan (
      .clk_i, .rst_ni,
      .cmp_id_i(ch_id[c]), .cmp_addr_i(ch_addr[c]), .ctl_i(ch_ctl[c]),
      .cmp_data_i(ch_data[c]), .dmask_i(ch_dmask[c]),
      .bus_valid_i, .bus_cpu_i, .bus_fetch_i, .bus_write_i, .bus_size_i,
      .bus_asid_i, .bus_addr_i, .bus_data_i,
      .match_o(ch_match[c]), .pre_o(ch_pre[c])
    );
  end

  brk_seq u_seq (
    .clk_i, .rst_ni,
    .seq_i(seq), .mode_wr_i(mode_wr), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .ma_i(ch_match[0]), .mb_i(ch_match[1]),
    .pre_a_i(ch_pre[0]), .pre_b_i(ch_pre[1]),
    .brk_o, .post_o(brk_post_o), .armed_o, .hit_a_o, .hit_b_o
  );

  // R10
  post_needs_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_post_o |-> brk_o);
endmodule

// File: tb/brk_unit_test.sv
module brk_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [3:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic bus_valid_i = 1'b0, bus_cpu_i = 1'b1, bus_fetch_i = 1'b0, bus_write_i = 1'b0;
  logic [1:0] bus_size_i = '0;
  logic [7:0] bus_asid_i = '0;
  logic [31:0] bus_addr_i = '0, bus_data_i = '0;
  logic brk_o, brk_post_o, armed_o, hit_a_o, hit_b_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brk_unit uut (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .bus_valid_i, .bus_cpu_i, .bus_fetch_i, .bus_write_i, .bus_size_i,
    .bus_asid_i, .bus_addr_i, .bus_data_i,
    .brk_o, .brk_post_o, .armed_o, .hit_a_o, .hit_b_o
  );

  typedef struct packed {
    logic [7:0]  asid;
    logic [31:0] addr;
    logic        fetch;
    logic        wr;
    logic [1:0]  size;
    logic        brk;
    logic        post;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h80, 32'h0000_0404, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1},
    '{8'h81, 32'h0000_0404, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h80, 32'h0000_0406, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h70, 32'h0000_8000, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    '{8'h70, 32'h0000_83FE, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    '{8'h70, 32'h0000_8400, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h70, 32'h0000_7FFE, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h80, 32'h0000_0404, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{8'h70, 32'h0000_8010, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0},
    '{8'h70, 32'h0000_8200, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0}
  };

  function automatic logic [31:0] ctl(input int am, input int kind, input int wr,
                                      input int size, input int cpu, input int post);
    return 32'(am) | (32'(kind) << 2) | (32'(wr) << 4) | (32'(size) << 5)
         | (32'(cpu) << 7) | (32'(post) << 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = 4'(a); cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic cyc(input logic [7:0] id, input logic [31:0] a, input logic [31:0] d,
                     input logic f, input logic w, input logic [1:0] s, input logic cpu);
    bus_valid_i = 1'b1; bus_asid_i = id; bus_addr_i = a; bus_data_i = d;
    bus_fetch_i = f; bus_write_i = w; bus_size_i = s; bus_cpu_i = cpu;
    @(negedge clk);
    bus_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 brk", 32'(brk_o), 0);
    chk("R1 hits", {30'd0, hit_a_o, hit_b_o}, 0);
    chk("R1 armed", 32'(armed_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    cyc(8'h00, 32'h0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1);
    chk("R1 off channels", 32'(brk_o), 0);

    // R12 table setup, independent mode
    wr(0, 32'h80); wr(1, 32'h0000_0404); wr(2, ctl(0, 1, 0, 0, 0, 1));
    wr(3, 32'h70); wr(4, 32'h0000_8010); wr(5, ctl(1, 1, 0, 0, 0, 0));
    wr(7, 32'hFFFF_FFFF); wr(8, 0);
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].asid, VEC[i].addr, 32'hA5A5_0000 + 32'(i), VEC[i].fetch, VEC[i].wr,
          VEC[i].size, 1'b1);
      chk($sformatf("R2/R3/R7 vec%0d brk", i), 32'(brk_o), 32'(VEC[i].brk));
      chk($sformatf("R10 vec%0d post", i), 32'(brk_post_o), 32'(VEC[i].post));
    end
    @(negedge clk);
    chk("R7 pulse ends", 32'(brk_o), 0);

    // R4 size
    wr(2, ctl(0, 1, 0, 2, 0, 1));
    cyc(8'h80, 32'h404, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R4 word match", 32'(brk_o), 1);
    cyc(8'h80, 32'h404, 0, 1'b1, 1'b0, 2'd3, 1'b1);
    chk("R4 size mismatch", 32'(brk_o), 0);

    // R5 cpu only
    wr(2, ctl(0, 1, 0, 0, 1, 1));
    cyc(8'h80, 32'h404, 0, 1'b1, 1'b0, 2'd0, 1'b0);
    chk("R5 non-cpu ignored", 32'(brk_o), 0);
    cyc(8'h80, 32'h404, 0, 1'b1, 1'b0, 2'd0, 1'b1);
    chk("R5 cpu hit", 32'(brk_o), 1);

    // R3 mask codes 2, 3
    wr(1, 32'h1000); wr(2, ctl(2, 1, 0, 0, 0, 0));
    cyc(8'h80, 32'h1FFE, 0, 1'b1, 1'b0, 2'd0, 1'b1);
    chk("R3 code2 in", 32'(brk_o), 1);
    cyc(8'h80, 32'h2000, 0, 1'b1, 1'b0, 2'd0, 1'b1);
    chk("R3 code2 out", 32'(brk_o), 0);
    wr(2, ctl(3, 1, 0, 0, 0, 0));
    cyc(8'h80, 32'hDEAD_0000, 0, 1'b1, 1'b0, 2'd0, 1'b1);
    chk("R3 code3 any", 32'(brk_o), 1);

    // R6 data compare on B, none on A
    wr(2, 0);
    wr(3, 32'h70); wr(4, 0); wr(5, ctl(3, 2, 1, 0, 0, 0));
    wr(6, 32'h1234_5600); wr(7, 32'h0000_00FF);
    cyc(8'h70, 32'h55, 32'h1234_56AB, 1'b0, 1'b1, 2'd3, 1'b1);
    chk("R6 masked data hit", 32'(brk_o), 1);
    cyc(8'h70, 32'h55, 32'h1234_57AB, 1'b0, 1'b1, 2'd3, 1'b1);
    chk("R6 data miss", 32'(brk_o), 0);
    cyc(8'h70, 32'h55, 32'h1234_56AB, 1'b0, 1'b0, 2'd3, 1'b1);
    chk("R4 direction miss", 32'(brk_o), 0);
    wr(5, 0);
    wr(0, 32'h80); wr(2, ctl(3, 2, 0, 0, 0, 0));
    cyc(8'h80, 32'h77, 32'hCAFE_F00D, 1'b0, 1'b0, 2'd1, 1'b1);
    chk("R6 A ignores data", 32'(brk_o), 1);

    // R10 timing priority
    wr(0, 32'h55); wr(1, 32'h100); wr(2, ctl(0, 1, 0, 0, 0, 1));
    wr(3, 32'h55); wr(4, 32'h100); wr(5, ctl(0, 1, 0, 0, 0, 0)); wr(7, 32'hFFFF_FFFF);
    cyc(8'h55, 32'h100, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R10 both brk", 32'(brk_o), 1);
    chk("R10 pre wins", 32'(brk_post_o), 0);
    wr(5, 0);
    cyc(8'h55, 32'h100, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R10 post only", 32'(brk_post_o), 1);

    // R8 sequential
    wr(9, 3);
    chk("R11 cleared", {30'd0, hit_a_o, hit_b_o}, 0);
    wr(8, 1);
    wr(0, 32'h80); wr(1, 32'h0003_7226); wr(2, ctl(0, 1, 0, 2, 0, 0));
    wr(3, 32'h70); wr(4, 32'h0003_722E); wr(5, ctl(0, 1, 0, 2, 0, 0));
    cyc(8'h70, 32'h0003_722E, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R8 early B no brk", 32'(brk_o), 0);
    chk("R8 early B no arm", 32'(armed_o), 0);
    chk("R11 early B no hit", 32'(hit_b_o), 0);
    cyc(8'h80, 32'h0003_7226, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R8 A no brk", 32'(brk_o), 0);
    chk("R8 A arms", 32'(armed_o), 1);
    chk("R11 A hit", 32'(hit_a_o), 1);
    cyc(8'h70, 32'h0003_722E, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R8 B brk", 32'(brk_o), 1);
    chk("R8 disarm", 32'(armed_o), 0);
    chk("R11 B hit", 32'(hit_b_o), 1);
    cyc(8'h70, 32'h0003_722E, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R8 B again ignored", 32'(brk_o), 0);

    // R9 mode write disarms
    cyc(8'h80, 32'h0003_7226, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R9 armed", 32'(armed_o), 1);
    wr(8, 1);
    chk("R9 disarmed", 32'(armed_o), 0);
    cyc(8'h70, 32'h0003_722E, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    chk("R9 B ignored", 32'(brk_o), 0);

    // R11 clear and race
    wr(9, 1);
    chk("R11 A cleared", 32'(hit_a_o), 0);
    chk("R11 B kept", 32'(hit_b_o), 1);
    cfg_we_i = 1'b1; cfg_addr_i = 4'd9; cfg_wdata_i = 32'h1;
    cyc(8'h80, 32'h0003_7226, 0, 1'b1, 1'b0, 2'd2, 1'b1);
    cfg_we_i = 1'b0;
    chk("R11 set beats clear", 32'(hit_a_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule